// File: doc/BRIEF.md
# Cascadable Bidirectional Column Data Loader

This block collects one display line of pixel data for a column driver that can be chained with identical drivers. On every clock edge it accepts one group of three 6-bit subpixels. A one-hot slot pointer steers each group into its place in a line register. A start pulse launches the pointer, and a single-clock cascade pulse is handed to the next driver once the last slot has been filled. A rising edge on the strobe input copies the whole line register into an output latch and clears the pointer. The latch drives the digital column codes toward the converters.

The fill direction can be chosen. With `dir_rgt` high, the start pulse enters on `sp_r_in`, the slots fill from slot 0 upward and the hand-off leaves on `sp_l_out`. With `dir_rgt` low the two sides swap roles. A reduced-column mode skips a fixed window of slots in the middle of the line. An invert input complements each group as it is stored. After reset the loader ignores start pulses until it has seen one strobe.

Top module: `col_loader`

## Requirements
- R1: Slot k (0-based) holds columns 3k+1, 3k+2 and 3k+3, which take lanes 0, 1 and 2 of `pix_in`. Lane l is `pix_in[6l+5:6l]`, bit 0 is the LSB, and column c appears at `col_out[6(c-1)+5:6(c-1)]` after a strobe.
- R2: With `dir_rgt`=1 the start pulse is taken from `sp_r_in`. The edge that samples it loads slot 0, and each following edge loads the next higher slot.
- R3: With `dir_rgt`=0 the start pulse is taken from `sp_l_in`. The edge that samples it loads slot GROUPS-1 (133), and each following edge loads the next lower slot.
- R4: The edge that loads the final slot raises the cascade output on the far side for exactly one clock. That side is `sp_l_out` when `dir_rgt`=1 and `sp_r_out` when `dir_rgt`=0. The other output stays low.
- R5: With `full_sel`=0, slots 64..69 (columns 193..210) are stepped over, so a line takes 128 loads. Columns in those slots keep their previous contents.
- R6: With `inv_en`=1 the bitwise complement of `pix_in` is stored. With `inv_en`=0 it is stored unchanged. The choice is made for each load separately.
- R7: On the clock edge where `strobe` is first seen high, `col_out` takes the line register as it stood before that edge. The pointer is cleared, and no load happens at that edge. `col_out` changes at no other time.
- R8: After reset, start pulses are ignored until the first strobe rising edge.
- R9: A start pulse that arrives while a line is being filled restarts filling at the first slot.
- R10: Clocks that arrive after the final slot has been filled, and before a new start, store nothing.
- R11: During and right after reset, `col_out` is all zero and both cascade outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low reset |
| dir_rgt | input | 1 | 1: fill upward, start on right side; 0: fill downward, start on left side |
| full_sel | input | 1 | 1: all 134 slots; 0: skip slots 64..69 (tie high when unused) |
| inv_en | input | 1 | Store the complement of the current group |
| strobe | input | 1 | Rising edge latches the line and clears the pointer |
| pix_in | input | 18 | Three 6-bit subpixel lanes |
| sp_r_in | input | 1 | Right-side start input |
| sp_l_in | input | 1 | Left-side start input |
| sp_r_out | output | 1 | Right-side cascade output (downward fill) |
| sp_l_out | output | 1 | Left-side cascade output (upward fill) |
| col_out | output | 2412 | Latched 6-bit code for each of 402 columns |

## Verification
On every cycle the assertions check the following. The pointer holds at most one slot. A strobe empties the pointer and refreshes the latch from the line register, while the latch stays unchanged otherwise. The cascade pulse lasts one clock and appears on only one side. Nothing is loaded before the first strobe. Slot ordering in each direction, the skipped window, per-load inversion, restarts and overrun clocks only show up in the latched contents. The bench scenarios expose them by comparing every column after each strobe against an index-based model.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;
  parameter int unsigned LANES_DEF   = 3;
  parameter int unsigned BITS_DEF    = 6;
  parameter int unsigned GROUPS_DEF  = 134;
  parameter int unsigned SKIP_LO_DEF = 64;
  parameter int unsigned SKIP_N_DEF  = 6;

  // slot g lies inside the window stepped over in reduced mode
  function automatic bit in_window(int unsigned g, int unsigned lo, int unsigned n);
    return (g >= lo) && (g < lo + n);
  endfunction
endpackage

// File: rtl/col_loader_pointer.sv
module col_loader_pointer
  import col_loader_pkg::*;
#(
  parameter int unsigned GROUPS  = GROUPS_DEF,
  parameter int unsigned SKIP_LO = SKIP_LO_DEF,
  parameter int unsigned SKIP_N  = SKIP_N_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              dir_rgt,
  input  logic              reduced,
  output logic [GROUPS-1:0] sel,
  output logic              last_hit
);
  localparam int unsigned SKIP_HI = SKIP_LO + SKIP_N;
  localparam logic [GROUPS-1:0] LOW_ONE  = {{(GROUPS-1){1'b0}}, 1'b1};
  localparam logic [GROUPS-1:0] HIGH_ONE = {1'b1, {(GROUPS-1){1'b0}}};

  logic [GROUPS-1:0] ptr_q, nxt;

  always_comb begin
    if (clr)        sel = '0;
    else if (start) sel = dir_rgt ? LOW_ONE : HIGH_ONE;
    else            sel = ptr_q;
  end

  assign last_hit = dir_rgt ? sel[GROUPS-1] : sel[0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_step
    localparam bit IN_WIN = in_window(g, SKIP_LO, SKIP_N);
    logic up_src, dn_src, up_jump, dn_jump;
    if (g > 0) begin : g_up
      assign up_src = sel[g-1] & ~(reduced & IN_WIN);
    end else begin : g_up0
      assign up_src = 1'b0;
    end
    if (g < GROUPS - 1) begin : g_dn
      assign dn_src = sel[g+1] & ~(reduced & IN_WIN);
    end else begin : g_dn0
      assign dn_src = 1'b0;
    end
    if (g == SKIP_HI) begin : g_uj
      assign up_jump = reduced & sel[SKIP_LO-1];
    end else begin : g_uj0
      assign up_jump = 1'b0;
    end
    if (g == SKIP_LO - 1) begin : g_dj
      assign dn_jump = reduced & sel[SKIP_HI];
    end else begin : g_dj0
      assign dn_jump = 1'b0;
    end
    assign nxt[g] = dir_rgt ? (up_src | up_jump) : (dn_src | dn_jump);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= nxt;
  end

  // R9: restarts never leave two live slots
  p_ptr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ptr_q))
    else $error("pointer holds more than one slot");
  // R7: strobe empties the pointer
  p_strobe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (ptr_q == '0))
    else $error("pointer not cleared by strobe");
endmodule

// File: rtl/col_loader_line.sv
module col_loader_line
  import col_loader_pkg::*;
#(
  parameter int unsigned GROUPS = GROUPS_DEF,
  parameter int unsigned GW     = LANES_DEF * BITS_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUPS-1:0]    sel,
  input  logic [GW-1:0]        din,
  output logic [GROUPS*GW-1:0] line
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      line[g*GW +: GW] <= '0;
      else if (sel[g]) line[g*GW +: GW] <= din;
    end
  end
endmodule

// File: rtl/col_loader.sv
module col_loader
  import col_loader_pkg::*;
#(
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned BITS    = BITS_DEF,
  parameter int unsigned GROUPS  = GROUPS_DEF,
  parameter int unsigned SKIP_LO = SKIP_LO_DEF,
  parameter int unsigned SKIP_N  = SKIP_N_DEF,
  localparam int unsigned GW     = LANES * BITS,
  localparam int unsigned COLS   = GROUPS * LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dir_rgt,
  input  logic                 full_sel,
  input  logic                 inv_en,
  input  logic                 strobe,
  input  logic [GW-1:0]        pix_in,
  input  logic                 sp_r_in,
  input  logic                 sp_l_in,
  output logic                 sp_r_out,
  output logic                 sp_l_out,
  output logic [COLS*BITS-1:0] col_out
);
  localparam int unsigned LW = GROUPS * GW;

  logic              strb_q, armed_q, cas_q;
  logic              strb_rise, start_go, last_hit;
  logic [GROUPS-1:0] sel;
  logic [GW-1:0]     din_eff;
  logic [LW-1:0]     line, latch_q;

  assign strb_rise = strobe & ~strb_q;
  assign start_go  = (dir_rgt ? sp_r_in : sp_l_in) & armed_q & ~strb_rise;
  assign din_eff   = pix_in ^ {GW{inv_en}};

  col_loader_pointer #(.GROUPS(GROUPS), .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(strb_rise), .start(start_go),
    .dir_rgt(dir_rgt), .reduced(~full_sel), .sel(sel), .last_hit(last_hit)
  );

  col_loader_line #(.GROUPS(GROUPS), .GW(GW)) u_line (
    .clk(clk), .rst_n(rst_n), .sel(sel), .din(din_eff), .line(line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q  <= 1'b0;
      armed_q <= 1'b0;
      cas_q   <= 1'b0;
      latch_q <= '0;
    end else begin
      strb_q <= strobe;
      cas_q  <= last_hit;
      if (strb_rise) begin
        armed_q <= 1'b1;
        latch_q <= line;
      end
    end
  end

  assign col_out  = latch_q;
  assign sp_l_out = cas_q & dir_rgt;
  assign sp_r_out = cas_q & ~dir_rgt;

  // R4: hand-off is one clock wide and on a single side
  p_cas_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) cas_q |=> !cas_q)
    else $error("cascade pulse longer than one clock");
  p_cas_side_r4: assert property (@(posedge clk) disable iff (!rst_n) !(sp_l_out && sp_r_out))
    else $error("cascade on both sides");
  // R8: nothing is stored before the first strobe
  p_idle_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n) !armed_q |-> (sel == '0))
    else $error("load before first strobe");
  // R7: the latch follows the line only at a strobe edge
  p_latch_take_r7: assert property (@(posedge clk) disable iff (!rst_n) strb_rise |=> (col_out == $past(line)))
    else $error("latch missed line contents");
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) !strb_rise |=> $stable(col_out))
    else $error("latch changed without strobe");
endmodule

// File: tb/col_loader_bench.sv
`timescale 1ns/1ps
module col_loader_bench;
  localparam int G = 134, COLS = 402, LO = 64, N = 6;

  logic clk = 0, rst_n = 0;
  logic dir_rgt = 1, full_sel = 1, inv_en = 0, strobe = 0;
  logic [17:0] pix_in = '0;
  logic sp_r_in = 0, sp_l_in = 0;
  logic sp_r_out, sp_l_out;
  logic [COLS*6-1:0] col_out;

  col_loader u_col_loader (
    .clk(clk), .rst_n(rst_n), .dir_rgt(dir_rgt), .full_sel(full_sel), .inv_en(inv_en),
    .strobe(strobe), .pix_in(pix_in), .sp_r_in(sp_r_in), .sp_l_in(sp_l_in),
    .sp_r_out(sp_r_out), .sp_l_out(sp_l_out), .col_out(col_out)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R11";
  logic [5:0] m_line [COLS];
  logic [5:0] m_lat  [COLS];
  int  m_idx = -1;
  bit  m_armed = 0, m_stq = 0, m_cas = 0;
  bit  finished = 0;

  function automatic int next_idx(int idx, bit up, bit full);
    int n;
    n = up ? idx + 1 : idx - 1;
    if (!full && n >= LO && n < LO + N) begin
      if (up) n = (idx == LO - 1) ? LO + N : -1;
      else    n = (idx == LO + N) ? LO - 1 : -1;
    end
    if (n < 0 || n >= G) n = -1;
    return n;
  endfunction

  function automatic logic [COLS*6-1:0] pack_lat();
    logic [COLS*6-1:0] v;
    for (int c = 0; c < COLS; c++) v[c*6 +: 6] = m_lat[c];
    return v;
  endfunction

  task automatic check_bit(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", cur_req, what, act, exp);
    end
  endtask

  task automatic check_cols();
    logic [COLS*6-1:0] e;
    e = pack_lat();
    checks++;
    if (col_out !== e) begin
      errors++;
      for (int c = 0; c < COLS; c++)
        if (col_out[c*6 +: 6] !== e[c*6 +: 6]) begin
          $display("FAIL %s column %0d: actual %0h expected %0h", cur_req, c + 1,
                   col_out[c*6 +: 6], e[c*6 +: 6]);
          break;
        end
    end
  endtask

  task automatic cyc(bit st, bit stb, bit inv, logic [17:0] d);
    bit rise;
    sp_r_in = dir_rgt ? st : 1'b0;
    sp_l_in = dir_rgt ? 1'b0 : st;
    strobe = stb; inv_en = inv; pix_in = d;
    rise = stb && !m_stq;
    m_stq = stb;
    if (rise) begin
      m_lat = m_line; m_idx = -1; m_armed = 1; m_cas = 0;
    end else begin
      if (st && m_armed) m_idx = dir_rgt ? 0 : G - 1;
      if (m_idx >= 0) begin
        for (int l = 0; l < 3; l++) m_line[m_idx*3 + l] = d[l*6 +: 6] ^ {6{inv}};
        m_cas = (m_idx == (dir_rgt ? G - 1 : 0));
        m_idx = next_idx(m_idx, dir_rgt, full_sel);
      end else m_cas = 0;
    end
    @(posedge clk); @(negedge clk);
    check_bit("left cascade", sp_l_out, dir_rgt && m_cas);
    check_bit("right cascade", sp_r_out, !dir_rgt && m_cas);
    check_cols();
  endtask

  task automatic latch_line();
    cyc(0, 1, 0, '0);
    cyc(0, 0, 0, '0);
  endtask

  task automatic fill(int loads, int extra);
    cyc(1, 0, $urandom_range(0, 1), $urandom);
    for (int i = 1; i < loads + extra; i++) cyc(0, 0, $urandom_range(0, 1), $urandom);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < COLS; c++) begin m_line[c] = '0; m_lat[c] = '0; end
    repeat (3) @(negedge clk);
    cur_req = "R11";
    check_bit("left cascade in reset", sp_l_out, 0);
    check_bit("right cascade in reset", sp_r_out, 0);
    check_cols();
    rst_n = 1;
    @(negedge clk);
    check_cols();

    cur_req = "R8";                      // start before first strobe ignored
    fill(5, 0);
    latch_line();

    cur_req = "R2";                      // upward fill, R1 lane mapping, R6 inversion
    cyc(1, 0, 0, {6'h3C, 6'h15, 6'h01});
    for (int i = 1; i < G; i++) cyc(0, 0, $urandom_range(0, 1), $urandom);
    cur_req = "R10";
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 18'h3FFFF);
    latch_line();
    cur_req = "R1";
    checks++;
    if (col_out[5:0] !== 6'h01 || col_out[11:6] !== 6'h15 || col_out[17:12] !== 6'h3C) begin
      errors++;
      $display("FAIL R1 first columns: actual %0h expected 3c1501", col_out[17:0]);
    end

    cur_req = "R3";                      // downward fill, R4 hand-off on right side
    dir_rgt = 0;
    fill(G, 4);
    latch_line();

    cur_req = "R6";
    dir_rgt = 1;
    cyc(1, 0, 1, 18'h0_0000);
    for (int i = 1; i < G; i++) cyc(0, 0, 1, {6'h2A, 6'h00, 6'h3F});
    latch_line();
    checks++;
    if (col_out[17:0] !== 18'h3FFFF) begin
      errors++;
      $display("FAIL R6 inverted zeros: actual %0h expected 3ffff", col_out[17:0]);
    end

    cur_req = "R5";                      // reduced mode in both directions
    full_sel = 0;
    fill(128, 3);
    latch_line();
    dir_rgt = 0;
    fill(128, 3);
    latch_line();
    full_sel = 1;

    cur_req = "R9";                      // restart mid-line
    dir_rgt = 1;
    fill(40, 0);
    fill(G, 2);
    latch_line();

    cur_req = "R7";                      // strobe mid-line, then random traffic
    fill(20, 0);
    latch_line();
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 299) == 0) dir_rgt = ~dir_rgt;
      if ($urandom_range(0, 299) == 0) full_sel = ~full_sel;
      cyc($urandom_range(0, 59) == 0, $urandom_range(0, 149) == 0,
          $urandom_range(0, 1), $urandom);
    end
    latch_line();

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule